// File: doc/BRIEF.md
# Restart Interrupt Mask and Serial Bit Controller

This block sits beside a small CPU core and holds the interrupt state for one non-maskable trap line and three maskable restart lines, named by their priority levels 7.5, 6.5 and 5.5. The core updates the masks and the serial output bit by presenting a mask command byte with a one-cycle write strobe. It turns the global interrupt enable on or off with two single-cycle strobes. It reads back one status byte that holds the serial input bit, the pending lines, the enable flag and the masks.

The block selects the highest-priority request that is eligible and offers it to the core on a valid/ready channel. The offer carries the source index and the fixed vector address, so the core needs no external acknowledge cycle to learn where to jump. The offer is back-pressured by `irq_ready`. Once `irq_valid` is raised, the index and the address stay unchanged until the cycle in which `irq_ready` is high, and that cycle is the acceptance. Changes to masks, to the enable flag or to the inputs made while an offer is waiting do not withdraw it or replace it.

Top module: `intc_mask_unit`

## Requirements
- R1: Reset sets the three masks to 1, clears the global enable, the pending 7.5 and trap latches and the serial output, and drops `irq_valid`. With `ser_in` low and all request lines low, the status byte reads 0x07.
- R2: On a command write with bit 6 set, `ser_out` takes bit 7 of the command. On any other cycle `ser_out` keeps its value.
- R3: Command bits 2, 1 and 0 replace the 7.5, 6.5 and 5.5 masks only when bit 3 of the same command is 1. A mask of 1 blocks that line and a mask of 0 lets it through.
- R4: A command write with bit 4 set clears the pending 7.5 latch.
- R5: Status bit 7 is `ser_in`. Bits 6, 5 and 4 are pending 7.5, the 6.5 input level and the 5.5 input level. Bit 3 is the global enable. Bits 2, 1 and 0 are the masks of 7.5, 6.5 and 5.5.
- R6: `ien_set` sets the global enable and `ien_clr` clears it. If both are high in the same cycle, the enable ends up clear.
- R7: A rising edge on `rst75_in` sets the pending 7.5 latch. The latch stays set after the input falls. An input that stays high does not set the latch again once it has been cleared.
- R8: The 6.5 and 5.5 lines are level sensitive. Each raises a request only while its input is high, its mask is 0 and the global enable is 1.
- R9: A rising edge on `trap_in` latches a trap request. The trap request is served whatever the masks and the global enable hold.
- R10: When several requests are eligible, the order is trap, then 7.5, then 6.5, then 5.5. The sources use `irq_idx` values 0, 1, 2 and 3 and vector addresses 0x0024, 0x003C, 0x0034 and 0x002C.
- R11: While `irq_valid` is high and `irq_ready` is low, `irq_valid`, `irq_idx` and `irq_vec` hold their values. An eligible request appears on `irq_valid` at the second clock edge after its line is latched (edge lines) or after it becomes eligible (level lines).
- R12: Accepting a maskable request clears the global enable, and accepting 7.5 also clears its pending latch. Accepting a trap clears the trap latch and leaves the global enable unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mask_wr | input | 1 | One-cycle strobe that applies `mask_wdata` |
| mask_wdata | input | 8 | Mask command byte (bit fields in R2 to R4) |
| ien_set | input | 1 | Sets the global interrupt enable |
| ien_clr | input | 1 | Clears the global interrupt enable |
| status | output | 8 | Status byte (layout in R5) |
| ser_in | input | 1 | Serial input bit |
| ser_out | output | 1 | Serial output bit |
| trap_in | input | 1 | Non-maskable trap line, edge latched |
| rst75_in | input | 1 | Restart 7.5 line, edge latched |
| rst65_in | input | 1 | Restart 6.5 line, level sensitive |
| rst55_in | input | 1 | Restart 5.5 line, level sensitive |
| irq_valid | output | 1 | Interrupt offer is valid |
| irq_ready | input | 1 | Core accepts the offer |
| irq_idx | output | 2 | Source index of the offer |
| irq_vec | output | ADDR_W | Vector address of the offer |

## Verification
The bench builds the block with its defaults: a 16-bit vector address and a stride of 4. With these values the trap, 7.5, 6.5 and 5.5 sources resolve to 0x0024, 0x003C, 0x0034 and 0x002C, and these exact addresses can be compared on the port. A table of command bytes steps through the gating of the serial bit and the masks. Directed sequences then hold offers under back-pressure and race the trap against 7.5. They also clear the 7.5 latch while its line stays high, and check which acceptances drop the global enable.

// File: rtl/intc_pkg.sv
package intc_pkg;

  typedef enum logic [1:0] {
    SRC_TRAP = 2'd0,
    SRC_R75  = 2'd1,
    SRC_R65  = 2'd2,
    SRC_R55  = 2'd3
  } irq_src_e;

  // Command byte fields; the core's encoding depends on these positions.
  localparam int CMD_SOUT    = 7;
  localparam int CMD_SOUT_EN = 6;
  localparam int CMD_CLR75   = 4;
  localparam int CMD_MASK_EN = 3;

  localparam int NUM_MASKABLE = 3;
  localparam int NUM_EDGE     = 2;

  // Vector slot per source; address = slot * stride.
  function automatic int unsigned vec_slot(irq_src_e s);
    case (s)
      SRC_TRAP: return 9;
      SRC_R75:  return 15;
      SRC_R65:  return 13;
      default:  return 11;
    endcase
  endfunction

endpackage

// File: rtl/intc_edge_latch.sv
module intc_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic clr,
  output logic pend
);
  logic prev_q;
  logic rise;

  assign rise = din & ~prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      prev_q <= din;
      if (rise)
        pend <= 1'b1;
      else if (clr)
        pend <= 1'b0;
    end
  end
endmodule

// File: rtl/intc_ctrl_regs.sv
module intc_ctrl_regs
  import intc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mask_wr,
  input  logic [7:0]              mask_wdata,
  input  logic                    ien_set,
  input  logic                    ien_clr,
  input  logic                    take_maskable,
  output logic [NUM_MASKABLE-1:0] masks,
  output logic                    ien,
  output logic                    ser_out
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      masks   <= '1;
      ien     <= 1'b0;
      ser_out <= 1'b0;
    end else begin
      if (mask_wr && mask_wdata[CMD_SOUT_EN])
        ser_out <= mask_wdata[CMD_SOUT];
      if (mask_wr && mask_wdata[CMD_MASK_EN])
        masks <= mask_wdata[NUM_MASKABLE-1:0];
      if (ien_clr || take_maskable)
        ien <= 1'b0;
      else if (ien_set)
        ien <= 1'b1;
    end
  end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
(
  input  logic                    trap_req,
  input  logic [NUM_MASKABLE-1:0] mreq,    // [2]=7.5 [1]=6.5 [0]=5.5
  output logic                    any_req,
  output irq_src_e                pick
);
  always_comb begin
    any_req = trap_req | (|mreq);
    pick    = SRC_R55;
    for (int i = 0; i < NUM_MASKABLE; i++) begin
      if (mreq[i])
        pick = irq_src_e'(NUM_MASKABLE - i);
    end
    if (trap_req)
      pick = SRC_TRAP;
  end
endmodule

// File: rtl/intc_mask_unit.sv
module intc_mask_unit
  import intc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int VEC_STRIDE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_wr,
  input  logic [7:0]        mask_wdata,
  input  logic              ien_set,
  input  logic              ien_clr,
  output logic [7:0]        status,
  input  logic              ser_in,
  output logic              ser_out,
  input  logic              trap_in,
  input  logic              rst75_in,
  input  logic              rst65_in,
  input  logic              rst55_in,
  output logic              irq_valid,
  input  logic              irq_ready,
  output logic [1:0]        irq_idx,
  output logic [ADDR_W-1:0] irq_vec
);
  localparam int EDGE_TRAP = 0;
  localparam int EDGE_R75  = 1;

  logic                    accept;
  irq_src_e                held_src;
  logic [NUM_MASKABLE-1:0] masks;
  logic                    ien;
  logic                    take_maskable;
  logic [NUM_EDGE-1:0]     edge_in, edge_clr, edge_pend;
  logic [NUM_MASKABLE-1:0] lines, mreq;
  logic                    any_req;
  irq_src_e                pick;

  assign accept        = irq_valid & irq_ready;
  assign take_maskable = accept & (held_src != SRC_TRAP);

  assign edge_in[EDGE_TRAP]  = trap_in;
  assign edge_in[EDGE_R75]   = rst75_in;
  assign edge_clr[EDGE_TRAP] = accept & (held_src == SRC_TRAP);
  assign edge_clr[EDGE_R75]  = (accept & (held_src == SRC_R75))
                             | (mask_wr & mask_wdata[CMD_CLR75]);

  for (genvar g = 0; g < NUM_EDGE; g++) begin : g_edge
    intc_edge_latch u_latch (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (edge_in[g]),
      .clr  (edge_clr[g]),
      .pend (edge_pend[g])
    );
  end

  intc_ctrl_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .mask_wr      (mask_wr),
    .mask_wdata   (mask_wdata),
    .ien_set      (ien_set),
    .ien_clr      (ien_clr),
    .take_maskable(take_maskable),
    .masks        (masks),
    .ien          (ien),
    .ser_out      (ser_out)
  );

  assign lines = {edge_pend[EDGE_R75], rst65_in, rst55_in};
  assign mreq  = lines & ~masks & {NUM_MASKABLE{ien}};

  intc_arbiter u_arb (
    .trap_req(edge_pend[EDGE_TRAP]),
    .mreq    (mreq),
    .any_req (any_req),
    .pick    (pick)
  );

  // Offer slot: captured when empty, held until accepted.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_valid <= 1'b0;
      held_src  <= SRC_TRAP;
    end else if (irq_valid) begin
      if (irq_ready)
        irq_valid <= 1'b0;
    end else if (any_req) begin
      irq_valid <= 1'b1;
      held_src  <= pick;
    end
  end

  assign irq_idx = held_src;
  assign irq_vec = ADDR_W'(vec_slot(held_src) * VEC_STRIDE);
  assign status  = {ser_in, lines, ien, masks};

endmodule

// File: rtl/intc_mask_unit_chk.sv
module intc_mask_unit_chk #(
  parameter int ADDR_W     = 16,
  parameter int VEC_STRIDE = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mask_wr,
  input logic [7:0]        mask_wdata,
  input logic              ien_set,
  input logic              ien_clr,
  input logic [7:0]        status,
  input logic              ser_in,
  input logic              ser_out,
  input logic              trap_in,
  input logic              rst75_in,
  input logic              rst65_in,
  input logic              rst55_in,
  input logic              irq_valid,
  input logic              irq_ready,
  input logic [1:0]        irq_idx,
  input logic [ADDR_W-1:0] irq_vec
);
  logic [ADDR_W-1:0] exp_vec;
  always_comb begin
    case (irq_idx)
      2'd0:    exp_vec = ADDR_W'(9 * VEC_STRIDE);
      2'd1:    exp_vec = ADDR_W'(15 * VEC_STRIDE);
      2'd2:    exp_vec = ADDR_W'(13 * VEC_STRIDE);
      default: exp_vec = ADDR_W'(11 * VEC_STRIDE);
    endcase
  end

  p_offer_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && !irq_ready |=> irq_valid && $stable(irq_idx) && $stable(irq_vec));

  p_ien_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && irq_ready && irq_idx != 2'd0 |=> !status[3]);

  p_trap_keeps_ien_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && irq_ready && irq_idx == 2'd0 && !ien_clr && !ien_set |=> $stable(status[3]));

  p_sout_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mask_wr && mask_wdata[6]) |=> $stable(ser_out));

  p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mask_wr && mask_wdata[3]) |=> $stable(status[2:0]));

  p_clr75_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr && mask_wdata[4] && !rst75_in |=> !status[6]);

  p_ien_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ien_clr |=> !status[3]);

  p_vec_map_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_vec == exp_vec);

  p_ser_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
    status[7] == ser_in && status[5] == rst65_in && status[4] == rst55_in);

endmodule

bind intc_mask_unit intc_mask_unit_chk #(.ADDR_W(ADDR_W), .VEC_STRIDE(VEC_STRIDE)) u_chk (.*);

// File: tb/sim_intc_mask_unit.sv
`timescale 1ns/1ps
module sim_intc_mask_unit;
  localparam int ADDR_W = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              mask_wr;
  logic [7:0]        mask_wdata;
  logic              ien_set, ien_clr;
  logic [7:0]        status;
  logic              ser_in, ser_out;
  logic              trap_in, rst75_in, rst65_in, rst55_in;
  logic              irq_valid, irq_ready;
  logic [1:0]        irq_idx;
  logic [ADDR_W-1:0] irq_vec;

  int  n_chk  = 0;
  int  n_fail = 0;
  logic done  = 1'b0;

  always #2 clk = ~clk;

  intc_mask_unit u0 (.*);

  // {command byte, expected status, expected ser_out}, from reset state
  localparam logic [16:0] VEC_TBL [10] = '{
    {8'h00, 8'h07, 1'b0},
    {8'hC0, 8'h07, 1'b1},
    {8'h80, 8'h07, 1'b1},
    {8'h40, 8'h07, 1'b0},
    {8'h08, 8'h00, 1'b0},
    {8'h0D, 8'h05, 1'b0},
    {8'h06, 8'h05, 1'b0},
    {8'h0A, 8'h02, 1'b0},
    {8'h88, 8'h00, 1'b0},
    {8'h0F, 8'h07, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] b);
    mask_wr = 1'b1; mask_wdata = b;
    tick();
    mask_wr = 1'b0; mask_wdata = 8'h00;
  endtask

  task automatic pulse_set();
    ien_set = 1'b1; tick(); ien_set = 1'b0;
  endtask

  task automatic take();
    irq_ready = 1'b1; tick(); irq_ready = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; mask_wr = 1'b0; mask_wdata = 8'h00; ien_set = 1'b0; ien_clr = 1'b0;
    ser_in = 1'b0; trap_in = 1'b0; rst75_in = 1'b0; rst65_in = 1'b0; rst55_in = 1'b0;
    irq_ready = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick();
    check("R1 status after reset", status, 8'h07);
    check("R1 ser_out after reset", ser_out, 0);
    check("R1 irq_valid after reset", irq_valid, 0);

    for (int i = 0; i < 10; i++) begin
      cmd(VEC_TBL[i][16:9]);
      check($sformatf("R3 R5 table %0d status", i), status, VEC_TBL[i][8:1]);
      check($sformatf("R2 table %0d ser_out", i), ser_out, VEC_TBL[i][0]);
    end

    // R5 / R8: level lines visible in status, masked so no offer
    ser_in = 1'b1; rst65_in = 1'b1; rst55_in = 1'b1;
    tick();
    check("R5 status layout", status, 8'hB7);
    pulse_set();
    check("R6 enable strobe", status, 8'hBF);
    tick(2);
    check("R8 masked lines give no offer", irq_valid, 0);

    // R8 / R11: unmask 5.5 only, then hold under back-pressure
    cmd(8'h0E);
    tick();
    check("R11 offer at second edge", irq_valid, 1);
    check("R8 5.5 index", irq_idx, 3);
    check("R10 5.5 vector", irq_vec, 16'h002C);
    cmd(8'h08);
    tick(2);
    check("R11 held valid", irq_valid, 1);
    check("R11 held index despite 6.5", irq_idx, 3);
    take();
    check("R12 accept drops valid", irq_valid, 0);
    check("R12 maskable accept clears enable", status[3], 0);
    tick(3);
    check("R8 no offer with enable off", irq_valid, 0);

    // R10: 6.5 beats 5.5
    cmd(8'h0C);
    pulse_set();
    tick();
    check("R10 6.5 over 5.5 index", irq_idx, 2);
    check("R10 6.5 vector", irq_vec, 16'h0034);
    check("R10 6.5 valid", irq_valid, 1);
    take();
    rst65_in = 1'b0; rst55_in = 1'b0;

    // R7 / R4: edge latch of 7.5
    cmd(8'h0F);
    pulse_set();
    rst75_in = 1'b1;
    tick();
    check("R7 rising edge latches 7.5", status[6], 1);
    rst75_in = 1'b0;
    tick(2);
    check("R7 latch holds after fall", status[6], 1);
    check("R3 masked 7.5 gives no offer", irq_valid, 0);
    cmd(8'h10);
    check("R4 clear-7.5 bit", status[6], 0);
    rst75_in = 1'b1;
    tick();
    cmd(8'h10);
    tick(2);
    check("R7 steady high does not relatch", status[6], 0);
    rst75_in = 1'b0;
    tick();

    // R9 / R10 / R12: trap beats 7.5, trap accept keeps enable
    cmd(8'h08);
    trap_in = 1'b1; rst75_in = 1'b1;
    tick(2);
    check("R10 trap first index", irq_idx, 0);
    check("R10 trap vector", irq_vec, 16'h0024);
    check("R9 trap valid", irq_valid, 1);
    take();
    check("R12 trap accept keeps enable", status[3], 1);
    tick();
    check("R10 7.5 next index", irq_idx, 1);
    check("R10 7.5 vector", irq_vec, 16'h003C);
    take();
    check("R12 7.5 accept clears latch and enable", status, 8'h80);
    trap_in = 1'b0; rst75_in = 1'b0;
    tick();

    // R9: trap with masks set and enable off
    cmd(8'h0F);
    trap_in = 1'b1;
    tick(2);
    check("R9 trap ignores masks and enable", irq_valid, 1);
    check("R9 trap index", irq_idx, 0);
    take();
    trap_in = 1'b0;

    // R6: clear wins
    ien_set = 1'b1; ien_clr = 1'b1;
    tick();
    ien_set = 1'b0; ien_clr = 1'b0;
    check("R6 clear beats set", status[3], 0);
    pulse_set();
    ien_clr = 1'b1; tick(); ien_clr = 1'b0;
    check("R6 disable strobe", status[3], 0);

    // R1: reset mid-run
    cmd(8'hC8);
    pulse_set();
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    check("R1 status after late reset", status, 8'h87);
    check("R1 ser_out after late reset", ser_out, 0);
    check("R1 valid after late reset", irq_valid, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog for all requirements actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule